// File: doc/BRIEF.md
# Banked Memory Address Decoder

This block turns the 16-bit address bus of an 8-bit processor into chip selects. The fixed map has these regions: base RAM in the lower half, a video-RAM window that can be enabled in the top 8 kB of that half, a 16 kB banked RAM window, eight 256-byte I/O slots, and a boot ROM that fills the remainder. Every select is active low. A select is asserted only while the bus clock enable (the phase-two qualifier) is high.

A 3-bit bank number lives in I/O slot 0. The processor writes it through the data bus and can read it back. The block forms a 17-bit physical address for the banked RAM from the bank number and the low 14 address bits. It also produces active-low read and write strobes, and it passes the low address byte to the expansion bus whenever one of the four upper slots is selected.

Top module: `bank_addr_decoder`

## Requirements
- R1: With `phi2` high, addresses 0x0000–0x7FFF assert `base_ram_n`. When `VRAM_EN` is 1, the range 0x6000–0x7FFF is excluded.
- R2: With `VRAM_EN`=1 (default) and `phi2` high, addresses 0x6000–0x7FFF assert `vram_n` in place of `base_ram_n`.
- R3: With `phi2` high, addresses 0x8000–0xBFFF assert `bank_ram_n`.
- R4: With `phi2` high, addresses 0xC000–0xC7FF assert `io_sel_n[k]`, where k is address bits 10:8. Bit k of the vector is slot k.
- R5: With `phi2` high, addresses 0xC800–0xFFFF assert `rom_n`.
- R6: While `phi2` is low, no select and no strobe is asserted. While `phi2` is high, exactly one select among `base_ram_n`, `vram_n`, `bank_ram_n`, `rom_n` and the eight `io_sel_n` bits is low.
- R7: The bank register resets to 0 on synchronous active-high `rst`. On a rising `clk` edge where `phi2` is high, `rw` is 0 and slot 0 is addressed, it loads `wdata[2:0]`.
- R8: A read (`rw`=1, `phi2` high) anywhere in slot 0 returns the bank number on `rdata[2:0]`, with `rdata[7:3]` equal to 0. At every other time `rdata` is 0.
- R9: `bank_addr` equals the bank number in bits 16:14 and address bits 13:0 in bits 13:0.
- R10: `oe_n` is low exactly when `phi2` is high and `rw` is 1. `we_n` is low exactly when `phi2` is high and `rw` is 0.
- R11: `exp_addr` carries address bits 7:0 while one of slots 4–7 is selected. Otherwise it is 0.
- R12: A write to slots 1–7, or a slot-0 write made with `phi2` low, leaves the bank number unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| phi2 | input | 1 | Bus phase clock enable; qualifies every select and strobe |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 16 | CPU address bus |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | Readback of the bank register (slot 0), else 0 |
| base_ram_n | output | 1 | Base RAM select, active low |
| vram_n | output | 1 | Video RAM select, active low |
| bank_ram_n | output | 1 | Banked RAM window select, active low |
| rom_n | output | 1 | Boot ROM select, active low |
| io_sel_n | output | 8 | Per-slot I/O selects, active low |
| bank_addr | output | 17 | Banked RAM physical address |
| exp_addr | output | 8 | Low address byte toward the expansion bus |
| oe_n | output | 1 | Read strobe, active low |
| we_n | output | 1 | Write strobe, active low |

## Verification
On every cycle the assertions check the following: the selects stay one-hot while `phi2` is high and all idle while it is low; the strobes match the bus direction; the bank register loads only on a qualified slot-0 write and holds otherwise; and slot-0 reads return the bank number. Only the bench scenarios can show the following: that each address boundary lands in the intended region and slot; that the physical bank address combines the right bits; and that the expansion byte is passed only for the upper four slots.

// File: rtl/bank_dec_pkg.sv
package bank_dec_pkg;

  // Decoded memory region of the current address.
  typedef enum logic [2:0] {
    RGN_BASE = 3'd0,
    RGN_VRAM = 3'd1,
    RGN_BANK = 3'd2,
    RGN_IO   = 3'd3,
    RGN_ROM  = 3'd4
  } region_e;

  // Region boundaries of the 16-bit map (inclusive low bounds).
  localparam logic [15:0] VRAM_LO = 16'h6000;
  localparam logic [15:0] BANK_LO = 16'h8000;
  localparam logic [15:0] IO_LO   = 16'hC000;
  localparam logic [15:0] ROM_LO  = 16'hC800;

endpackage

// File: rtl/bdec_region.sv
module bdec_region
  import bank_dec_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter bit VRAM_EN = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);

  always_comb begin
    if (addr >= ROM_LO)
      region = RGN_ROM;
    else if (addr >= IO_LO)
      region = RGN_IO;
    else if (addr >= BANK_LO)
      region = RGN_BANK;
    else if (VRAM_EN && addr >= VRAM_LO)
      region = RGN_VRAM;
    else
      region = RGN_BASE;
  end

endmodule

// File: rtl/bdec_io_slots.sv
module bdec_io_slots #(
  parameter int SLOT_W = 3,
  localparam int SLOTS = 1 << SLOT_W
) (
  input  logic              en,
  input  logic [SLOT_W-1:0] slot,
  output logic [SLOTS-1:0]  sel_n
);

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign sel_n[k] = !(en && slot == SLOT_W'(k));
  end

endmodule

// File: rtl/bdec_bank_reg.sv
module bdec_bank_reg #(
  parameter int BANK_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [BANK_W-1:0] bank
);

  always_ff @(posedge clk) begin
    if (rst)
      bank <= '0;
    else if (wr_en)
      bank <= wdata[BANK_W-1:0];
  end

endmodule

// File: rtl/bank_addr_decoder.sv
module bank_addr_decoder
  import bank_dec_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int BANK_W  = 3,
  parameter int WIN_W   = 14,
  parameter int SLOT_W  = 3,
  parameter int EXP_W   = 8,
  parameter bit VRAM_EN = 1'b1,
  localparam int SLOTS  = 1 << SLOT_W,
  localparam int PHYS_W = BANK_W + WIN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phi2,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              base_ram_n,
  output logic              vram_n,
  output logic              bank_ram_n,
  output logic              rom_n,
  output logic [SLOTS-1:0]  io_sel_n,
  output logic [PHYS_W-1:0] bank_addr,
  output logic [EXP_W-1:0]  exp_addr,
  output logic              oe_n,
  output logic              we_n
);

  region_e           region;
  logic [BANK_W-1:0] bank;
  logic              io_en;
  logic              slot0;
  logic              exp_hit;

  bdec_region #(.ADDR_W(ADDR_W), .VRAM_EN(VRAM_EN)) u_region (
    .addr   (addr),
    .region (region)
  );

  assign io_en = phi2 && region == RGN_IO;

  bdec_io_slots #(.SLOT_W(SLOT_W)) u_slots (
    .en    (io_en),
    .slot  (addr[8 +: SLOT_W]),
    .sel_n (io_sel_n)
  );

  assign slot0 = !io_sel_n[0];

  bdec_bank_reg #(.BANK_W(BANK_W), .DATA_W(DATA_W)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .wr_en (slot0 && !rw),
    .wdata (wdata),
    .bank  (bank)
  );

  assign base_ram_n = !(phi2 && region == RGN_BASE);
  assign vram_n     = !(phi2 && region == RGN_VRAM);
  assign bank_ram_n = !(phi2 && region == RGN_BANK);
  assign rom_n      = !(phi2 && region == RGN_ROM);

  assign oe_n = !(phi2 && rw);
  assign we_n = !(phi2 && !rw);

  assign bank_addr = {bank, addr[WIN_W-1:0]};

  // Upper half of the slot range feeds the expansion bus.
  assign exp_hit  = !(&io_sel_n[SLOTS-1:SLOTS/2]);
  assign exp_addr = exp_hit ? addr[EXP_W-1:0] : '0;

  assign rdata = (slot0 && rw) ? DATA_W'(bank) : '0;

endmodule

// File: rtl/bank_addr_decoder_chk.sv
module bank_addr_decoder_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SLOTS  = 8,
  parameter int PHYS_W = 17,
  parameter int EXP_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              phi2,
  input logic              rw,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              base_ram_n,
  input logic              vram_n,
  input logic              bank_ram_n,
  input logic              rom_n,
  input logic [SLOTS-1:0]  io_sel_n,
  input logic [PHYS_W-1:0] bank_addr,
  input logic [EXP_W-1:0]  exp_addr,
  input logic              oe_n,
  input logic              we_n
);

  logic [SLOTS+3:0] sels;
  logic             s0_wr;
  assign sels  = ~{base_ram_n, vram_n, bank_ram_n, rom_n, io_sel_n};
  assign s0_wr = phi2 && !rw && !io_sel_n[0];

  p_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    phi2 |-> $onehot(sels));

  p_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !phi2 |-> (sels == '0 && oe_n && we_n));

  p_read_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> (phi2 && rw && we_n));

  p_write_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (phi2 && !rw && oe_n));

  p_reset_r7: assert property (@(posedge clk)
    rst |=> bank_addr[PHYS_W-1:PHYS_W-3] == 3'd0);

  p_load_r7: assert property (@(posedge clk) disable iff (rst)
    s0_wr |=> bank_addr[PHYS_W-1:PHYS_W-3] == $past(wdata[2:0]));

  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !s0_wr |=> $stable(bank_addr[PHYS_W-1:PHYS_W-3]));

  p_readback_r8: assert property (@(posedge clk) disable iff (rst)
    (phi2 && rw && !io_sel_n[0]) |->
      rdata == DATA_W'(bank_addr[PHYS_W-1:PHYS_W-3]));

endmodule

bind bank_addr_decoder bank_addr_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOTS(SLOTS), .PHYS_W(PHYS_W), .EXP_W(EXP_W)
) u_chk (.*);

// File: tb/bank_addr_decoder_bench.sv
module bank_addr_decoder_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        phi2 = 1'b0;
  logic        rw = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        base_ram_n, vram_n, bank_ram_n, rom_n, oe_n, we_n;
  logic [7:0]  io_sel_n;
  logic [16:0] bank_addr;
  logic [7:0]  exp_addr;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  bank_addr_decoder u_bank_addr_decoder (
    .clk(clk), .rst(rst), .phi2(phi2), .rw(rw), .addr(addr), .wdata(wdata),
    .rdata(rdata), .base_ram_n(base_ram_n), .vram_n(vram_n),
    .bank_ram_n(bank_ram_n), .rom_n(rom_n), .io_sel_n(io_sel_n),
    .bank_addr(bank_addr), .exp_addr(exp_addr), .oe_n(oe_n), .we_n(we_n)
  );

  // Select vector: {base, vram, bank, rom, io[7:0]}, active high.
  logic [11:0] sel_obs;
  assign sel_obs = ~{base_ram_n, vram_n, bank_ram_n, rom_n, io_sel_n};

  localparam int NV = 16;
  localparam logic [15:0] V_ADDR [NV] = '{
    16'h0000, 16'h5FFF, 16'h6000, 16'h7FFF, 16'h8000, 16'hBFFF,
    16'hC000, 16'hC1FF, 16'hC2AA, 16'hC3FF, 16'hC400, 16'hC5FF,
    16'hC680, 16'hC7FF, 16'hC800, 16'hFFFF };
  localparam logic [11:0] V_SEL [NV] = '{
    12'h800, 12'h800, 12'h400, 12'h400, 12'h200, 12'h200,
    12'h001, 12'h002, 12'h004, 12'h008, 12'h010, 12'h020,
    12'h040, 12'h080, 12'h100, 12'h100 };
  localparam string V_TAG [NV] = '{
    "R1", "R1", "R2", "R2", "R3", "R3", "R4", "R4",
    "R4", "R4", "R4", "R4", "R4", "R4", "R5", "R5" };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic p, input logic r, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    phi2 = p; rw = r; addr = a; wdata = d;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    phi2 = 1'b0; rw = 1'b1; wdata = '0;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // Reset state: idle bus, bank 0
    chk("R6 reset selects idle", {20'd0, sel_obs}, 32'd0);
    chk("R10 reset strobes", {30'd0, oe_n, we_n}, 32'd3);
    chk("R7 reset bank", {29'd0, bank_addr[16:14]}, 32'd0);

    // Map walk (reads)
    for (int i = 0; i < NV; i++) begin
      bus(1'b1, 1'b1, V_ADDR[i], 8'h00);
      chk(V_TAG[i], {20'd0, sel_obs}, {20'd0, V_SEL[i]});
    end

    // phi2 low: nothing asserted
    bus(1'b0, 1'b0, 16'hC000, 8'h00);
    chk("R6 phi2 low selects", {20'd0, sel_obs}, 32'd0);
    chk("R10 phi2 low strobes", {30'd0, oe_n, we_n}, 32'd3);

    // Strobes
    bus(1'b1, 1'b1, 16'h1234, 8'h00);
    chk("R10 read strobes", {30'd0, oe_n, we_n}, 32'd1);
    bus(1'b1, 1'b0, 16'h1234, 8'h00);
    chk("R10 write strobes", {30'd0, oe_n, we_n}, 32'd2);

    // Bank write, then readback and physical address
    bus(1'b1, 1'b0, 16'hC000, 8'hFD);
    idle();
    chk("R7 bank load", {29'd0, bank_addr[16:14]}, 32'd5);
    bus(1'b1, 1'b1, 16'h9234, 8'h00);
    chk("R9 phys addr", {15'd0, bank_addr}, {15'd0, 3'd5, 14'h1234});
    bus(1'b1, 1'b1, 16'hC0A5, 8'h00);
    chk("R8 readback", {24'd0, rdata}, 32'h05);
    bus(1'b1, 1'b1, 16'hC100, 8'h00);
    chk("R8 other slot reads 0", {24'd0, rdata}, 32'h00);

    // Writes that must not change the bank
    bus(1'b1, 1'b0, 16'hC100, 8'h02);
    idle();
    bus(1'b1, 1'b1, 16'hC000, 8'h00);
    chk("R12 slot1 write ignored", {24'd0, rdata}, 32'h05);
    bus(1'b0, 1'b0, 16'hC000, 8'h03);
    idle();
    bus(1'b1, 1'b1, 16'hC000, 8'h00);
    chk("R12 phi2 low write ignored", {24'd0, rdata}, 32'h05);

    // Top bank value
    bus(1'b1, 1'b0, 16'hC0FF, 8'h07);
    idle();
    bus(1'b1, 1'b1, 16'hBFFF, 8'h00);
    chk("R9 top bank", {15'd0, bank_addr}, {15'd0, 17'h1FFFF});

    // Expansion bus byte
    bus(1'b1, 1'b1, 16'hC5AB, 8'h00);
    chk("R11 exp slot", {24'd0, exp_addr}, 32'hAB);
    bus(1'b1, 1'b1, 16'hC2AB, 8'h00);
    chk("R11 internal slot", {24'd0, exp_addr}, 32'h00);

    // Reset mid-run
    idle();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R7 re-reset bank", {29'd0, bank_addr[16:14]}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule